// File: doc/BRIEF.md
# Integer and Fractional 8x8 Multiplier

This block multiplies two byte-wide operands and returns a 16-bit product split into a high byte and a low byte, meant for a fixed destination register pair (high byte to the upper register, low byte to the lower register). Register-file write-back and instruction decode are handled outside the block. A 3-bit mode selects how each operand is interpreted: both unsigned, both two's complement, or a two's-complement first operand times an unsigned second operand. A fractional flag can be added to any of these. In fractional form the full product is shifted left by one bit.

A start strobe launches an operation. The block captures the operands on that edge, forms the product in the following cycle, and raises a one-cycle done pulse two clocks after acceptance. Only the zero flag and the carry flag are produced. Carry is the product's top bit before any fractional shift. Zero reports whether the final 16-bit result is zero. A start that arrives while an operation is in flight is dropped.

Top module: `frac_mul_unit`

## Requirements
- R1: Mode encoding: mode[2] set selects fractional form. mode[1:0] = 00 treats both operands as unsigned, 01 treats both as two's complement, 10 treats op_a as two's complement and op_b as unsigned, and 11 is handled as 00.
- R2: In unsigned modes the 16-bit result equals op_a times op_b, each taken as 0..255.
- R3: In signed modes the result equals the 16-bit two's-complement product of the two signed operands.
- R4: In mixed modes the result equals the 16-bit two's-complement product of signed op_a and unsigned op_b.
- R5: In fractional modes the result is the integer product of the same sign mode shifted left by one bit. Bit 0 is zero and the product's bit 15 is discarded.
- R6: flag_c equals bit 15 of the product before any fractional shift.
- R7: flag_z is 1 exactly when the final 16-bit result {res_hi, res_lo} is zero.
- R8: A start sampled while idle is accepted. done is high for exactly one cycle, after the second rising edge counting the accepting edge as the first, and the result and flags are valid in that same cycle.
- R9: A start sampled while an accepted operation is still in its first stage is ignored. It produces no done pulse and does not change the result.
- R10: res_hi, res_lo, flag_z and flag_c hold their values in every cycle in which done is low.
- R11: After synchronous reset, res_hi, res_lo, flag_z, flag_c and done are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch strobe, sampled on the rising edge |
| mode | input | 3 | Operation select, encoded as in R1 |
| op_a | input | 8 | First operand |
| op_b | input | 8 | Second operand |
| res_hi | output | 8 | High byte of the result, bound for the upper register of the pair |
| res_lo | output | 8 | Low byte of the result, bound for the lower register of the pair |
| flag_z | output | 1 | Zero flag of the final result |
| flag_c | output | 1 | Carry flag: product bit 15 before the shift |
| done | output | 1 | One-cycle completion pulse |

## Verification
On every cycle the assertions check several timing and fractional properties:
- the done pulse lasts a single cycle;
- every accepted start is followed by done at the fixed distance;
- a start arriving while busy leaves the pipeline empty;
- the outputs stay stable while done is low;
- fractional results have a clear bit 0.

The arithmetic itself can only be shown by the bench's scenarios. These cover the values in each sign mode, the carry being taken before the shift, zero detection, and how the reserved sign code behaves. They use boundary operands such as 0x80, 0xFF and zero.

// File: rtl/fmul_pkg.sv
package fmul_pkg;

    typedef enum logic [1:0] {
        SIGN_UU  = 2'b00,
        SIGN_SS  = 2'b01,
        SIGN_SU  = 2'b10,
        SIGN_RSV = 2'b11
    } sign_kind_e;

    typedef struct packed {
        logic frac;
        logic a_signed;
        logic b_signed;
    } op_ctl_t;

    // R1: bit 2 selects fractional, bits 1:0 select operand signedness
    function automatic op_ctl_t decode_mode(input logic [2:0] m);
        op_ctl_t c;
        c.frac = m[2];
        unique case (sign_kind_e'(m[1:0]))
            SIGN_SS: begin c.a_signed = 1'b1; c.b_signed = 1'b1; end
            SIGN_SU: begin c.a_signed = 1'b1; c.b_signed = 1'b0; end
            default: begin c.a_signed = 1'b0; c.b_signed = 1'b0; end
        endcase
        return c;
    endfunction

endpackage

// File: rtl/fmul_issue.sv
module fmul_issue
    import fmul_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [2:0]        mode,
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    output logic              busy,
    output op_ctl_t           ctl_q,
    output logic [DATA_W-1:0] a_q,
    output logic [DATA_W-1:0] b_q
);

    logic accept;
    assign accept = start && !busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            ctl_q <= '0;
            a_q   <= '0;
            b_q   <= '0;
        end else begin
            busy <= accept;
            if (accept) begin
                ctl_q <= decode_mode(mode);
                a_q   <= op_a;
                b_q   <= op_b;
            end
        end
    end

    AST_BUSY_DROP: assert property (@(posedge clk) disable iff (rst)
        (start && busy) |=> !busy); // R9

endmodule

// File: rtl/fmul_core.sv
module fmul_core
    import fmul_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  op_ctl_t             ctl,
    input  logic [DATA_W-1:0]   a,
    input  logic [DATA_W-1:0]   b,
    output logic [2*DATA_W-1:0] result,
    output logic                carry
);

    localparam int EXT_W  = DATA_W + 1;
    localparam int PROD_W = 2 * DATA_W;

    logic signed [EXT_W-1:0]   a_x;
    logic signed [EXT_W-1:0]   b_x;
    logic signed [2*EXT_W-1:0] full;
    logic [PROD_W-1:0]         raw;

    // one extra bit per operand lets a single signed array cover all sign modes
    assign a_x  = {ctl.a_signed & a[DATA_W-1], a};
    assign b_x  = {ctl.b_signed & b[DATA_W-1], b};
    assign full = a_x * b_x;
    assign raw  = full[PROD_W-1:0];

    assign carry  = raw[PROD_W-1];
    assign result = ctl.frac ? {raw[PROD_W-2:0], 1'b0} : raw;

endmodule

// File: rtl/fmul_retire.sv
module fmul_retire #(
    parameter int DATA_W = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                valid_in,
    input  logic [2*DATA_W-1:0] result,
    input  logic                carry,
    output logic [2*DATA_W-1:0] product,
    output logic                z,
    output logic                c,
    output logic                done
);

    always_ff @(posedge clk) begin
        if (rst) begin
            product <= '0;
            z       <= 1'b0;
            c       <= 1'b0;
            done    <= 1'b0;
        end else begin
            done <= valid_in;
            if (valid_in) begin
                product <= result;
                z       <= (result == '0);
                c       <= carry;
            end
        end
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R8

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable({product, z, c})); // R10

endmodule

// File: rtl/frac_mul_unit.sv
module frac_mul_unit
    import fmul_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [2:0]        mode,
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    output logic [DATA_W-1:0] res_hi,
    output logic [DATA_W-1:0] res_lo,
    output logic              flag_z,
    output logic              flag_c,
    output logic              done
);

    localparam int PROD_W = 2 * DATA_W;

    logic              busy;
    op_ctl_t           ctl_q;
    logic [DATA_W-1:0] a_q;
    logic [DATA_W-1:0] b_q;
    logic [PROD_W-1:0] core_res;
    logic              core_c;
    logic [PROD_W-1:0] product;

    fmul_issue #(.DATA_W(DATA_W)) u_issue (
        .clk(clk), .rst(rst), .start(start), .mode(mode),
        .op_a(op_a), .op_b(op_b),
        .busy(busy), .ctl_q(ctl_q), .a_q(a_q), .b_q(b_q)
    );

    fmul_core #(.DATA_W(DATA_W)) u_core (
        .ctl(ctl_q), .a(a_q), .b(b_q),
        .result(core_res), .carry(core_c)
    );

    fmul_retire #(.DATA_W(DATA_W)) u_retire (
        .clk(clk), .rst(rst), .valid_in(busy),
        .result(core_res), .carry(core_c),
        .product(product), .z(flag_z), .c(flag_c), .done(done)
    );

    assign res_hi = product[PROD_W-1:DATA_W];
    assign res_lo = product[DATA_W-1:0];

    AST_ACCEPT_TO_DONE: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> ##1 done); // R8

    AST_FRAC_EVEN: assert property (@(posedge clk) disable iff (rst)
        (done && $past(ctl_q.frac)) |-> (res_lo[0] == 1'b0)); // R5

endmodule

// File: tb/frac_mul_unit_tb.sv
`timescale 1ns/1ps
module frac_mul_unit_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic [2:0] mode = '0;
    logic [7:0] op_a = '0;
    logic [7:0] op_b = '0;
    logic [7:0] res_hi, res_lo;
    logic       flag_z, flag_c, done;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    frac_mul_unit u_dut (
        .clk(clk), .rst(rst), .start(start), .mode(mode),
        .op_a(op_a), .op_b(op_b),
        .res_hi(res_hi), .res_lo(res_lo),
        .flag_z(flag_z), .flag_c(flag_c), .done(done)
    );

    // {mode, a, b, expected result, expected C, expected Z}
    localparam int NV = 12;
    localparam logic [36:0] VEC [NV] = '{
        {3'b000, 8'hFF, 8'hFF, 16'hFE01, 1'b1, 1'b0}, // R2
        {3'b001, 8'hFF, 8'hFF, 16'h0001, 1'b0, 1'b0}, // R3
        {3'b010, 8'hFF, 8'hFF, 16'hFF01, 1'b1, 1'b0}, // R4
        {3'b100, 8'h80, 8'h80, 16'h8000, 1'b0, 1'b0}, // R5
        {3'b101, 8'h80, 8'h80, 16'h8000, 1'b0, 1'b0}, // R5
        {3'b110, 8'h80, 8'h02, 16'hFE00, 1'b1, 1'b0}, // R6
        {3'b000, 8'h00, 8'h5A, 16'h0000, 1'b0, 1'b1}, // R7
        {3'b001, 8'h7F, 8'h81, 16'hC0FF, 1'b1, 1'b0}, // R3
        {3'b101, 8'hC0, 8'h40, 16'hE000, 1'b1, 1'b0}, // R6
        {3'b010, 8'h12, 8'h34, 16'h03A8, 1'b0, 1'b0}, // R4
        {3'b011, 8'hFF, 8'h02, 16'h01FE, 1'b0, 1'b0}, // R1
        {3'b110, 8'h7F, 8'hFF, 16'hFD02, 1'b0, 1'b0}  // R5
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic run_op(input logic [2:0] m, input logic [7:0] a, input logic [7:0] b,
                          input logic [15:0] ep, input logic ec, input logic ez, input string tag);
        @(negedge clk);
        mode = m; op_a = a; op_b = b; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check({tag, " R8 done early"}, 32'(done), 32'd0);
        @(negedge clk);
        check({tag, " R8 done"}, 32'(done), 32'd1);
        check({tag, " result"}, {16'h0, res_hi, res_lo}, {16'h0, ep});
        check({tag, " R6 carry"}, 32'(flag_c), 32'(ec));
        check({tag, " R7 zero"}, 32'(flag_z), 32'(ez));
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R11 hi", 32'(res_hi), 32'd0);
        check("R11 lo", 32'(res_lo), 32'd0);
        check("R11 flags", {30'd0, flag_z, flag_c}, 32'd0);
        check("R11 done", 32'(done), 32'd0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            run_op(VEC[i][36:34], VEC[i][33:26], VEC[i][25:18],
                   VEC[i][17:2], VEC[i][1], VEC[i][0], $sformatf("vec%0d", i));
        end

        // R8: done lasts one cycle
        @(negedge clk);
        check("R8 done single cycle", 32'(done), 32'd0);

        // R10: inputs change without start, outputs hold
        mode = 3'b001; op_a = 8'h03; op_b = 8'h05;
        repeat (3) @(negedge clk);
        check("R10 hold", {16'h0, res_hi, res_lo}, 32'h0000FD02);
        check("R10 hold done", 32'(done), 32'd0);

        // R9: start held over the busy cycle, second operands ignored
        mode = 3'b000; op_a = 8'h10; op_b = 8'h10; start = 1'b1;
        @(negedge clk);
        op_a = 8'h02; op_b = 8'h03;
        @(negedge clk);
        start = 1'b0;
        check("R9 first done", 32'(done), 32'd1);
        check("R9 first result", {16'h0, res_hi, res_lo}, 32'h00000100);
        @(negedge clk);
        check("R9 no second done", 32'(done), 32'd0);
        @(negedge clk);
        check("R9 no second done later", 32'(done), 32'd0);
        check("R9 result kept", {16'h0, res_hi, res_lo}, 32'h00000100);

        // R7 with fractional zero, R1 reserved code with fraction bit
        run_op(3'b111, 8'h00, 8'hFF, 16'h0000, 1'b0, 1'b1, "R7 frac zero");
        run_op(3'b111, 8'h80, 8'h80, 16'h8000, 1'b0, 1'b0, "R1 reserved frac");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule